// File: doc/BRIEF.md
# Bus Word ASCII Record Formatter

This block turns one decoded 16-bit serial-bus word, together with the receiver's status flags, into a fixed 21-character ASCII text line. It emits the line one byte at a time on a valid/ready byte stream, so the stream can feed a UART transmitter or a stream FIFO directly. A one-cycle word strobe hands over the word type (command/status or data), a long-gap flag, a parity-good flag, an inversion-active flag and the payload. All of them are latched when the strobe is taken.

Each line has five fields separated by semicolons and ends with a carriage return:

- a four-letter sync token;
- three flag fields, each a letter followed by a `0` or `1` digit;
- the payload as `Hx` followed by four upper-case hex digits.

While a line is being sent the block reports busy. A strobe that arrives during that time is discarded and raises an overflow flag.

Top module: `word_ascii_fmt`

## Requirements
- R1: After reset, `busy`, `byte_valid` and `overflow` are all 0.
- R2: A `word_valid` pulse seen while idle is taken at that clock edge. From the next cycle, `busy` and `byte_valid` are 1, and both stay 1 until the line has been fully accepted.
- R3: Byte indices 0..3 carry "CMDS" (0x43 0x4D 0x44 0x53) when `word_is_cmd` was 1 at capture, and "DATA" (0x44 0x41 0x54 0x41) otherwise.
- R4: Index 5 is 'D' (0x44) and index 6 is the gap flag. Index 8 is 'P' (0x50) and index 9 is the parity-good flag. Index 11 is 'I' (0x49) and index 12 is the inversion flag. Each flag digit is '1' (0x31) when the flag is set and '0' (0x30) when it is clear.
- R5: Indices 4, 7, 10 and 13 are ';' (0x3B).
- R6: Index 14 is 'H' (0x48) and index 15 is 'x' (0x78). Indices 16..19 are the payload nibbles, most significant first. Values 0..9 are sent as 0x30..0x39, and values 10..15 as upper-case 'A'..'F' (0x41..0x46).
- R7: Index 20 is a carriage return (0x0D). A line is exactly 21 bytes, and a line feed (0x0A) is never sent.
- R8: While `byte_valid` is 1 and `byte_ready` is 0, `byte_data` and `byte_valid` stay unchanged. The byte index advances only on a cycle where `byte_valid` and `byte_ready` are both 1.
- R9: `busy` falls in the cycle after the carriage return is accepted, and not before.
- R10: A `word_valid` pulse while `busy` is 1 is dropped. It includes a pulse in the cycle in which the carriage return is accepted. The line in progress keeps the values captured at the strobe, and `overflow` reads 1 from the next cycle. `overflow` stays 1 until the next word is taken, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | One-cycle strobe: a decoded word is present |
| word_is_cmd | input | 1 | 1 = command/status sync, 0 = data sync |
| gap_long | input | 1 | 1 = gap before the word exceeded 4 us |
| parity_ok | input | 1 | 1 = received parity was good |
| invert_on | input | 1 | 1 = receiver is inverting the data |
| word_data | input | 16 | Decoded payload |
| busy | output | 1 | A line is being emitted |
| overflow | output | 1 | A strobe was dropped since the last taken word |
| byte_data | output | 8 | ASCII character of the current index |
| byte_valid | output | 1 | `byte_data` is valid |
| byte_ready | input | 1 | Downstream accepts `byte_data` |

## Verification
The bench sends all sixteen combinations of the four flags, so that each flag digit and both sync tokens are separated from their neighbours. It also sends a payload sweep that places every nibble value in every hex position, which separates the digit/letter boundary and the nibble order. Each line is drained under three ready patterns: always ready, alternating, and one-in-four. These patterns tell a correct hold under back-pressure apart from skipped or repeated characters. Strobes injected in the middle of a line and in the carriage-return cycle, carrying complemented fields, show whether a dropped word leaks into the line in progress and whether the overflow flag sets and clears.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    typedef struct packed {
        logic sync_cmd;
        logic gap_long;
        logic par_ok;
        logic inv_on;
    } wflags_t;

    // index of the first hex digit; all other characters are fixed in number
    localparam int HEX_POS     = 16;
    localparam int FIXED_CHARS = 17;

    localparam logic [7:0] CH_SEP = 8'h3B;
    localparam logic [7:0] CH_CR  = 8'h0D;

    function automatic logic [7:0] hex_ascii(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction

    function automatic logic [7:0] bit_ascii(input logic b);
        return b ? 8'h31 : 8'h30;
    endfunction

endpackage

// File: rtl/fmt_capture.sv
module fmt_capture
    import fmt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  wflags_t           flags_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              rec_done,
    output logic              start,
    output logic              busy,
    output logic              overflow,
    output wflags_t           flags_q,
    output logic [DATA_W-1:0] data_q
);

    typedef struct packed {
        logic              busy;
        logic              ovf;
        wflags_t           flags;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        start = 1'b0;
        if (s_q.busy) begin
            if (word_valid) s_d.ovf  = 1'b1;
            if (rec_done)   s_d.busy = 1'b0;
        end else if (word_valid) begin
            start     = 1'b1;
            s_d.busy  = 1'b1;
            s_d.ovf   = 1'b0;
            s_d.flags = flags_in;
            s_d.data  = data_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = s_q.busy;
    assign overflow = s_q.ovf;
    assign flags_q  = s_q.flags;
    assign data_q   = s_q.data;

endmodule

// File: rtl/fmt_seq.sv
module fmt_seq #(
    parameter int REC_LEN = 21,
    localparam int IDX_W  = $clog2(REC_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_LEN - 1);

    logic [IDX_W-1:0] idx_d, idx_q;

    assign last = (idx_q == LAST_IDX);

    always_comb begin
        idx_d = idx_q;
        if (start)        idx_d = '0;
        else if (advance) idx_d = last ? '0 : idx_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;

endmodule

// File: rtl/fmt_charsel.sv
module fmt_charsel
    import fmt_pkg::*;
#(
    parameter int DATA_W  = 16,
    localparam int NIB    = DATA_W / 4,
    localparam int IDX_W  = $clog2(FIXED_CHARS + NIB)
) (
    input  logic [IDX_W-1:0]  idx,
    input  wflags_t           flags,
    input  logic [DATA_W-1:0] data,
    output logic [7:0]        ch
);

    logic [3:0] nib [NIB];

    for (genvar g = 0; g < NIB; g++) begin : g_nib
        assign nib[g] = data[DATA_W-1-4*g -: 4];
    end

    always_comb begin
        case (int'(idx))
            0:              ch = flags.sync_cmd ? 8'h43 : 8'h44;
            1:              ch = flags.sync_cmd ? 8'h4D : 8'h41;
            2:              ch = flags.sync_cmd ? 8'h44 : 8'h54;
            3:              ch = flags.sync_cmd ? 8'h53 : 8'h41;
            4, 7, 10, 13:   ch = CH_SEP;
            5:              ch = 8'h44;
            6:              ch = bit_ascii(flags.gap_long);
            8:              ch = 8'h50;
            9:              ch = bit_ascii(flags.par_ok);
            11:             ch = 8'h49;
            12:             ch = bit_ascii(flags.inv_on);
            14:             ch = 8'h48;
            15:             ch = 8'h78;
            default:        ch = CH_CR;
        endcase
        for (int k = 0; k < NIB; k++) begin
            if (int'(idx) == HEX_POS + k) ch = hex_ascii(nib[k]);
        end
    end

endmodule

// File: rtl/word_ascii_fmt.sv
module word_ascii_fmt
    import fmt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic              word_is_cmd,
    input  logic              gap_long,
    input  logic              parity_ok,
    input  logic              invert_on,
    input  logic [DATA_W-1:0] word_data,
    output logic              busy,
    output logic              overflow,
    output logic [7:0]        byte_data,
    output logic              byte_valid,
    input  logic              byte_ready
);

    localparam int NIB     = DATA_W / 4;
    localparam int REC_LEN = FIXED_CHARS + NIB;
    localparam int IDX_W   = $clog2(REC_LEN);

    wflags_t           flags_in, flags_q;
    logic [DATA_W-1:0] data_q;
    logic [IDX_W-1:0]  idx;
    logic              start, last, advance, rec_done;

    assign flags_in = '{sync_cmd: word_is_cmd, gap_long: gap_long,
                        par_ok: parity_ok, inv_on: invert_on};

    assign byte_valid = busy;
    assign advance    = busy & byte_ready;
    assign rec_done   = advance & last;

    fmt_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid),
        .flags_in(flags_in), .data_in(word_data), .rec_done(rec_done),
        .start(start), .busy(busy), .overflow(overflow),
        .flags_q(flags_q), .data_q(data_q)
    );

    fmt_seq #(.REC_LEN(REC_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
        .idx(idx), .last(last)
    );

    fmt_charsel #(.DATA_W(DATA_W)) u_sel (
        .idx(idx), .flags(flags_q), .data(data_q), .ch(byte_data)
    );

endmodule

// File: rtl/fmt_checker.sv
module fmt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       word_valid,
    input logic       word_is_cmd,
    input logic       busy,
    input logic       overflow,
    input logic [7:0] byte_data,
    input logic       byte_valid,
    input logic       byte_ready
);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && !byte_ready |=> byte_valid && $stable(byte_data));

    a_r9_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(byte_valid && byte_ready && byte_data == 8'h0D));

    a_r10_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        busy && word_valid |=> overflow);

    a_r10_ovf_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && word_valid |=> !overflow && busy);

    a_r3_first: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && word_valid |=> byte_data == ($past(word_is_cmd) ? 8'h43 : 8'h44));

    a_r7_no_lf: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> byte_data != 8'h0A);

endmodule

bind word_ascii_fmt fmt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_is_cmd(word_is_cmd),
    .busy(busy), .overflow(overflow), .byte_data(byte_data),
    .byte_valid(byte_valid), .byte_ready(byte_ready)
);

// File: tb/sim_word_ascii_fmt.sv
module sim_word_ascii_fmt;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0, word_is_cmd = 1'b0, gap_long = 1'b0;
    logic        parity_ok = 1'b0, invert_on = 1'b0;
    logic [15:0] word_data = '0;
    logic        busy, overflow, byte_valid;
    logic        byte_ready = 1'b0;
    logic [7:0]  byte_data;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    word_ascii_fmt u0 (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_is_cmd(word_is_cmd),
        .gap_long(gap_long), .parity_ok(parity_ok), .invert_on(invert_on),
        .word_data(word_data), .busy(busy), .overflow(overflow),
        .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_char(input int i, input bit c, input bit g,
                                    input bit p, input bit v, input logic [15:0] d);
        string tok;
        int n;
        tok = c ? "CMDS" : "DATA";
        if (i < 4) return int'(tok[i]);
        if (i == 4 || i == 7 || i == 10 || i == 13) return 59;
        if (i == 5) return 68;
        if (i == 6) return 48 + int'(g);
        if (i == 8) return 80;
        if (i == 9) return 48 + int'(p);
        if (i == 11) return 73;
        if (i == 12) return 48 + int'(v);
        if (i == 14) return 72;
        if (i == 15) return 120;
        if (i < 20) begin
            n = (int'(d) >> (4 * (19 - i))) % 16;
            return (n < 10) ? 48 + n : 55 + n;
        end
        return 13;
    endfunction

    function automatic string req_of(input int i);
        if (i < 4) return "R3";
        if (i == 4 || i == 7 || i == 10 || i == 13) return "R5";
        if (i < 14) return "R4";
        if (i < 20) return "R6";
        return "R7";
    endfunction

    // mode 0: always ready, 1: alternating, 2: one cycle in four
    task automatic run_record(input bit c, input bit g, input bit p, input bit v,
                              input logic [15:0] d, input int mode, input int inject_at);
        int  idx = 0;
        int  cyc = 0;
        bit  stalled = 0;
        bit  rdy;
        logic [7:0] held = '0;
        @(negedge clk);
        byte_ready  = 1'b0;
        word_valid  = 1'b1;
        word_is_cmd = c; gap_long = g; parity_ok = p; invert_on = v; word_data = d;
        @(negedge clk);
        word_valid  = 1'b0;
        // scramble inputs: they must not affect the latched line
        word_is_cmd = ~c; gap_long = ~g; parity_ok = ~p; invert_on = ~v; word_data = ~d;
        chk(busy == 1'b1, "R2 busy", int'(busy), 1);
        chk(overflow == 1'b0, "R10 cleared on accept", int'(overflow), 0);
        while (idx < 21) begin
            if (stalled) chk(byte_data == held, "R8 hold", int'(byte_data), int'(held));
            rdy = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : (cyc % 4 == 3);
            byte_ready = rdy;
            word_valid = (cyc == inject_at);
            chk(byte_valid == 1'b1, "R2 valid", int'(byte_valid), 1);
            if (idx == 20) chk(busy == 1'b1, "R9 busy before CR", int'(busy), 1);
            if (rdy) begin
                chk(int'(byte_data) == exp_char(idx, c, g, p, v, d), req_of(idx),
                    int'(byte_data), exp_char(idx, c, g, p, v, d));
                idx++;
                stalled = 0;
            end else begin
                held = byte_data;
                stalled = 1;
            end
            @(negedge clk);
            word_valid = 1'b0;
            cyc++;
        end
        byte_ready = 1'b0;
        chk(busy == 1'b0, "R9 busy falls", int'(busy), 0);
        chk(byte_valid == 1'b0, "R7 no 22nd byte", int'(byte_valid), 0);
        if (inject_at >= 0)
            chk(overflow == 1'b1, "R10 overflow set", int'(overflow), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(byte_valid == 1'b0, "R1 valid", int'(byte_valid), 0);
        chk(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 idle after reset", int'(busy), 0);

        // all flag combinations under every ready pattern
        for (int f = 0; f < 16; f++) begin
            for (int m = 0; m < 3; m++) begin
                run_record(f[3], f[2], f[1], f[0], 16'(f * 16'h1111) ^ 16'h5A3C, m, -1);
            end
        end

        // every nibble value in every hex position
        for (int n = 0; n < 16; n++) begin
            logic [3:0] a = 4'(n);
            run_record(n[0], n[1], n[2], n[3], {a, a + 4'd1, a + 4'd2, a + 4'd3}, n % 3, -1);
        end

        // dropped strobes: mid-line, during stall, and in the CR-accept cycle
        run_record(1'b1, 1'b0, 1'b1, 1'b0, 16'hBEEF, 0, 5);
        run_record(1'b0, 1'b1, 1'b0, 1'b1, 16'h0F9A, 2, 2);
        run_record(1'b1, 1'b1, 1'b1, 1'b1, 16'hC0DE, 0, 20);
        run_record(1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, 1, -1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule